// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a transaction left half finished, typically with a slave still driving SDA low in the middle of a byte. On a start pulse it takes control of both lines through open-drain pull-low overrides. It pulses SCL so the stuck slave can shift out its remaining bits and let go of SDA. It then forces a STOP condition so the main bus controller returns to a known idle state.

Every override change is held for a fixed number of microsecond ticks, supplied by an external prescaler. The incoming SCL and SDA levels pass through a two-flop synchronizer before any decision is based on them. Clocking stops early once SDA reads high with SCL released. If another device holds SCL low, the sequence aborts without a STOP and raises a stuck-SCL flag that stays set until the next start.

Top module: `i2c_bus_recover`

## Requirements
- R1: Out of reset both overrides are released (scl_low_o = 0, sda_low_o = 0), and busy_o, done_o and scl_stuck_o are 0.
- R2: A start_i pulse seen while idle makes busy_o 1 from the next cycle on. A start_i pulse while busy_o is 1 is ignored and leaves the sequence unchanged.
- R3: Every change of scl_low_o or sda_low_o made by the timer is held for exactly STEP_US (default 5) tick_i pulses before the next change.
- R4: The clocking phase makes at most 2*MAX_CLKS (default 18) changes of scl_low_o, ending with SCL released. After the last change it goes straight to the STOP, without sampling SDA.
- R5: Before each change, while scl_low_o is 0, a synchronized SDA reading of 1 (with SCL high) ends clocking and starts the STOP at once.
- R6: Before each change, while scl_low_o is 0, a synchronized SCL reading of 0 aborts. The abort sets scl_stuck_o, leaves both overrides released, never asserts sda_low_o, and pulses done_o.
- R7: The STOP asserts scl_low_o and sda_low_o together, releases scl_low_o STEP_US ticks later, and releases sda_low_o a further STEP_US ticks later. sda_low_o is never 1 outside the STOP.
- R8: done_o is a single-cycle pulse at the end of the sequence, in the same cycle that busy_o returns to 0. For a STOP this is the cycle in which sda_low_o is released.
- R9: scl_stuck_o, once set, stays 1 until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted only while idle |
| tick_i | input | 1 | One-cycle microsecond tick from the prescaler |
| scl_i | input | 1 | Sampled SCL line level (asynchronous) |
| sda_i | input | 1 | Sampled SDA line level (asynchronous) |
| scl_low_o | output | 1 | 1 pulls SCL low through the open-drain driver |
| sda_low_o | output | 1 | 1 pulls SDA low through the open-drain driver |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| scl_stuck_o | output | 1 | SCL found held low by another device |

## Verification
The assertions check on every cycle that:
- the overrides stay put while a step is timing;
- the toggle count never passes its cap;
- SDA is pulled only inside the STOP and is released after SCL;
- done_o lasts one cycle and coincides with idle;
- the stuck flag changes only at an abort or an accepted start.

Only the bench scenarios can show the sequence as a whole. These cover a slave that lets go of SDA after a few clocks, one that never does, a bus already free, SCL stuck at start, and SCL grabbed in mid-sequence. The scoreboard compares every override edge, and its spacing in ticks, against the expected order.

// File: rtl/i2c_rcv_pkg.sv
`timescale 1ns/1ps
package i2c_rcv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_WAIT,
    ST_STOP_LOW,
    ST_STOP_SDA
  } rcv_state_e;
endpackage

// File: rtl/i2c_rcv_sync.sv
`timescale 1ns/1ps
module i2c_rcv_sync #(
  parameter int N_LINES = 2,
  parameter int STAGES  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] lines_i,
  output logic [N_LINES-1:0] lines_o
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    // Bus idles high; reset to released level
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '1;
      else         pipe_q <= {pipe_q[STAGES-2:0], lines_i[g]};
    end
    assign lines_o[g] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_rcv_step_timer.sv
`timescale 1ns/1ps
module i2c_rcv_step_timer #(
  parameter int STEP_TICKS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int CW = (STEP_TICKS < 2) ? 1 : $clog2(STEP_TICKS);
  localparam logic [CW-1:0] LAST = CW'(STEP_TICKS - 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  assign expire_o = run_q && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (expire_o) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q <= LAST));
  p_idle_cnt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (cnt_q == '0));
endmodule

// File: rtl/i2c_rcv_fsm.sv
`timescale 1ns/1ps
module i2c_rcv_fsm
  import i2c_rcv_pkg::*;
#(
  parameter int MAX_CLKS = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic scl_s_i,
  input  logic sda_s_i,
  input  logic step_done_i,
  output logic tmr_start_o,
  output logic scl_ovr_o,
  output logic sda_ovr_o,
  output logic busy_o,
  output logic done_o,
  output logic stuck_o
);
  localparam int MAX_TOG = 2 * MAX_CLKS;
  localparam int TCW     = $clog2(MAX_TOG + 1);
  localparam logic [TCW-1:0] TOG_LIMIT = TCW'(MAX_TOG);

  rcv_state_e     state_q, state_n;
  logic [TCW-1:0] cnt_q, cnt_n;
  logic           scl_q, scl_n, sda_q, sda_n;
  logic           done_q, done_n, err_q, err_n;
  logic           tmr_start;

  always_comb begin
    state_n   = state_q;
    cnt_n     = cnt_q;
    scl_n     = scl_q;
    sda_n     = sda_q;
    done_n    = 1'b0;
    err_n     = err_q;
    tmr_start = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_n = ST_CHECK;
          cnt_n   = '0;
          err_n   = 1'b0;
          scl_n   = 1'b0;
          sda_n   = 1'b0;
        end
      end
      ST_CHECK: begin
        if (cnt_q == TOG_LIMIT) begin
          state_n   = ST_STOP_LOW;
          scl_n     = 1'b1;
          sda_n     = 1'b1;
          tmr_start = 1'b1;
        end else if (!scl_q && !scl_s_i) begin
          // another device holds SCL: no STOP
          state_n = ST_IDLE;
          err_n   = 1'b1;
          done_n  = 1'b1;
        end else if (!scl_q && sda_s_i) begin
          state_n   = ST_STOP_LOW;
          scl_n     = 1'b1;
          sda_n     = 1'b1;
          tmr_start = 1'b1;
        end else begin
          state_n   = ST_WAIT;
          scl_n     = !scl_q;
          cnt_n     = cnt_q + TCW'(1);
          tmr_start = 1'b1;
        end
      end
      ST_WAIT: begin
        if (step_done_i) state_n = ST_CHECK;
      end
      ST_STOP_LOW: begin
        if (step_done_i) begin
          state_n   = ST_STOP_SDA;
          scl_n     = 1'b0;
          tmr_start = 1'b1;
        end
      end
      ST_STOP_SDA: begin
        if (step_done_i) begin
          state_n = ST_IDLE;
          sda_n   = 1'b0;
          done_n  = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      scl_q   <= scl_n;
      sda_q   <= sda_n;
      done_q  <= done_n;
      err_q   <= err_n;
    end
  end

  assign tmr_start_o = tmr_start;
  assign scl_ovr_o   = scl_q;
  assign sda_ovr_o   = sda_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign stuck_o     = err_q;

  p_start_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i) |=> (state_q == ST_CHECK));
  p_hold_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !step_done_i) |=> ($stable(scl_q) && $stable(sda_q)));
  p_toggle_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TOG_LIMIT);
  p_abort_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> (!scl_q && !sda_q && done_q));
  p_sda_stop_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_q |-> (state_q == ST_STOP_LOW || state_q == ST_STOP_SDA));
  p_sda_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_q) |-> (!scl_q && $past(!scl_q)));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (state_q == ST_IDLE));
  p_err_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !(state_q == ST_IDLE && start_i)) |=> err_q);
  p_err_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i) |=> !err_q);
endmodule

// File: rtl/i2c_bus_recover.sv
`timescale 1ns/1ps
module i2c_bus_recover #(
  parameter int STEP_US     = 5,
  parameter int MAX_CLKS    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_low_o,
  output logic sda_low_o,
  output logic busy_o,
  output logic done_o,
  output logic scl_stuck_o
);
  logic [1:0] lines_s;
  logic       tmr_start, step_done;

  i2c_rcv_sync #(.N_LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lines_i ({sda_i, scl_i}),
    .lines_o (lines_s)
  );

  i2c_rcv_step_timer #(.STEP_TICKS(STEP_US)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (tmr_start),
    .tick_i   (tick_i),
    .expire_o (step_done)
  );

  i2c_rcv_fsm #(.MAX_CLKS(MAX_CLKS)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .scl_s_i     (lines_s[0]),
    .sda_s_i     (lines_s[1]),
    .step_done_i (step_done),
    .tmr_start_o (tmr_start),
    .scl_ovr_o   (scl_low_o),
    .sda_ovr_o   (sda_low_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .stuck_o     (scl_stuck_o)
  );
endmodule

// File: tb/i2c_bus_recover_tb.sv
`timescale 1ns/1ps
module i2c_bus_recover_tb;
  localparam int STEP = 5;
  localparam int TDIV = 4;

  typedef struct {
    logic  scl, sda, dn, er, bz;
    int    gap;
    string tag;
  } ev_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, tick = 1'b0;
  logic scl_low, sda_low, busy, done, stuck;
  logic scl_hold = 1'b0, sda_hold = 1'b0;
  logic scl_force = 1'b0;
  int   sda_rel_after = 0, scl_stick_after = 0, rises = 0;
  logic prev_low = 1'b0;
  int   div = 0;
  int   n_chk = 0, n_fail = 0;
  ev_t  exp_q[$];

  wire scl_line = !scl_low && !scl_hold;
  wire sda_line = !sda_low && !sda_hold;

  always #4 clk = ~clk;

  i2c_bus_recover u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tick_i(tick),
    .scl_i(scl_line), .sda_i(sda_line),
    .scl_low_o(scl_low), .sda_low_o(sda_low), .busy_o(busy),
    .done_o(done), .scl_stuck_o(stuck)
  );

  always @(negedge clk) begin
    div  <= (div == TDIV - 1) ? 0 : div + 1;
    tick <= rst_n && (div == TDIV - 1);
  end

  // slave / foreign-master model
  always @(negedge clk) begin
    if (prev_low && !scl_low) rises = rises + 1;
    prev_low = scl_low;
    sda_hold <= (rises < sda_rel_after);
    scl_hold <= scl_force || ((scl_stick_after != 0) && (rises >= scl_stick_after));
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic s, input logic d, input logic dn, input logic er,
                      input logic bz, input int gap, input string tag);
    ev_t e;
    e.scl = s; e.sda = d; e.dn = dn; e.er = er; e.bz = bz; e.gap = gap; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor / scoreboard
  logic ps = 1'b0, pd = 1'b0;
  int   gap_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (tick) gap_cnt = gap_cnt + 1;
      if (scl_low != ps || sda_low != pd || done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected event {scl,sda,done}", {scl_low, sda_low, done}, 0);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          check({scl_low, sda_low, done, stuck, busy} == {e.scl, e.sda, e.dn, e.er, e.bz},
                e.tag, "event {scl,sda,done,stuck,busy}",
                {scl_low, sda_low, done, stuck, busy}, {e.scl, e.sda, e.dn, e.er, e.bz});
          if (e.gap >= 0)
            check(gap_cnt == e.gap, e.tag, "ticks since previous change", gap_cnt, e.gap);
        end
        gap_cnt = 0;
      end
      ps = scl_low;
      pd = sda_low;
    end
  end

  task automatic configure(input int rel, input int stick, input logic force_low);
    sda_rel_after   = rel;
    scl_stick_after = stick;
    scl_force       = force_low;
    rises           = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", busy, 1);
  endtask

  task automatic wait_end(input string tag);
    while (!done) @(negedge clk);
    repeat (8) @(negedge clk);
    check(exp_q.size() == 0, tag, "pending expected events", exp_q.size(), 0);
  endtask

  task automatic push_stop(input string first_tag);
    push(1, 1, 0, 0, 1, STEP, first_tag);
    push(0, 1, 0, 0, 1, STEP, "R7");
    push(0, 0, 1, 0, 0, STEP, "R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({scl_low, sda_low, busy, done, stuck} == 5'b0, "R1", "outputs in reset",
          {scl_low, sda_low, busy, done, stuck}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({scl_low, sda_low, busy, done, stuck} == 5'b0, "R1", "outputs after reset",
          {scl_low, sda_low, busy, done, stuck}, 0);

    // A: slave releases SDA on the 3rd SCL rise -> early STOP (R5, R3)
    configure(3, 0, 1'b0);
    push(1, 0, 0, 0, 1, -1, "R2");
    for (int i = 1; i < 6; i++) push(i % 2 == 0, 0, 0, 0, 1, STEP, "R3");
    push_stop("R5");
    do_start();
    wait_end("R5");

    // B: slave never releases: full 18 toggles, extra start ignored (R4, R2)
    configure(1000, 0, 1'b0);
    push(1, 0, 0, 0, 1, -1, "R4");
    for (int i = 1; i < 18; i++) push(i % 2 == 0, 0, 0, 0, 1, STEP, "R4");
    push_stop("R4");
    do_start();
    repeat (30) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_end("R2");

    // C: bus already free: immediate STOP (R5, R7)
    configure(0, 0, 1'b0);
    push(1, 1, 0, 0, 1, -1, "R5");
    push(0, 1, 0, 0, 1, STEP, "R7");
    push(0, 0, 1, 0, 0, STEP, "R8");
    do_start();
    wait_end("R7");

    // D: SCL stuck low from the start -> abort, no STOP (R6)
    configure(1000, 0, 1'b1);
    push(0, 0, 1, 1, 0, -1, "R6");
    do_start();
    wait_end("R6");
    repeat (20) @(negedge clk);
    check(stuck == 1'b1, "R9", "stuck flag held", stuck, 1);
    check(sda_low == 1'b0, "R6", "sda override after abort", sda_low, 0);

    // E: SCL grabbed after 2 rises -> mid-sequence abort, flag cleared by start (R9, R6)
    configure(1000, 2, 1'b0);
    push(1, 0, 0, 0, 1, -1, "R9");
    push(0, 0, 0, 0, 1, STEP, "R3");
    push(1, 0, 0, 0, 1, STEP, "R3");
    push(0, 0, 0, 0, 1, STEP, "R3");
    push(0, 0, 1, 1, 0, STEP, "R6");
    do_start();
    check(stuck == 1'b0, "R9", "stuck flag after start", stuck, 0);
    wait_end("R6");

    // C again after an abort: flag cleared, normal STOP
    configure(0, 0, 1'b0);
    push(1, 1, 0, 0, 1, -1, "R9");
    push(0, 1, 0, 0, 1, STEP, "R7");
    push(0, 0, 1, 0, 0, STEP, "R8");
    do_start();
    wait_end("R8");
    check(busy == 1'b0, "R8", "busy after done", busy, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1..: run did not finish, actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule